// File: doc/BRIEF.md
# AXI4-Lite Pipelined Register Bridge

This block sits between an AXI4-Lite master and a simple register backend. Each AXI4-Lite read or write becomes one single-cycle request on the backend bus. The backend answers every request after a fixed number of cycles, and answers them in the order they were issued. The bridge keeps several transactions in flight at once. Answers wait in a per-channel buffer until the master takes them on the B or R channel.

The bridge limits how many transactions may be open at one time. The limit is the larger of the two backend latencies plus two. A higher limit would not raise throughput; it would only add logic and queueing delay. Each answer buffer is exactly as deep as this limit, so neither buffer can overrun.

Bursts, address decoding and protection checks are not part of this block. The protection inputs are accepted and have no effect.

Top module: `axil_regbus_bridge`

## Requirements
- R1: While reset is high and on the first cycle after it, b_valid, r_valid and rq_valid are low. Once reset has been released with nothing pending, aw_ready, w_ready and ar_ready are high.
- R2: A write request goes to the backend only after both an AW beat and a W beat have been captured. Either beat may come first. While a beat is held and waits for its partner, the ready signal of that channel stays low.
- R3: The number of open transactions never exceeds MAX_OUT = max(RD_LAT, WR_LAT) + 2. A transaction opens when its request is issued and closes when its response handshake completes on B or R. While MAX_OUT transactions are open, aw_ready, w_ready and ar_ready are all low.
- R4: At most one backend request is issued per cycle. An AR handshake issues a read in that same cycle. A write pair that is ready in that cycle waits, and is issued on a later cycle.
- R5: rq_wmask is the byte strobe expanded to bits: mask bit i equals w_strb[i/8]. The bench backend writes only the masked bits.
- R6: Write responses return on B in write issue order. Read responses return on R in read issue order, each carrying the data of its own read.
- R7: If rs_err is set, the response code is SLVERR, 2'b10. Otherwise the code is OKAY, 2'b00. This holds for both b_resp and r_resp.
- R8: aw_prot and ar_prot have no effect on the data or the response.
- R9: While b_valid or r_valid is high and its ready is low, the valid stays high and the response payload stays unchanged.
- R10: With B and R stalled, the bridge accepts exactly MAX_OUT transactions. All of them are then delivered once the master becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write address |
| aw_prot | input | 3 | Write protection attributes (ignored) |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte write strobes |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read address |
| ar_prot | input | 3 | Read protection attributes (ignored) |
| r_valid | output | 1 | Read response valid |
| r_ready | input | 1 | Read response ready |
| r_data | output | DATA_W | Read data |
| r_resp | output | 2 | Read response code |
| rq_valid | output | 1 | Backend request strobe |
| rq_write | output | 1 | Backend request is a write |
| rq_addr | output | ADDR_W | Backend request address |
| rq_wdata | output | DATA_W | Backend write data |
| rq_wmask | output | DATA_W | Backend per-bit write mask |
| rs_valid | input | 1 | Backend response strobe |
| rs_rdata | input | DATA_W | Backend read data |
| rs_err | input | 1 | Backend error flag |

## Verification
The bench builds the bridge with ADDR_W=8, DATA_W=32, RD_LAT=3 and WR_LAT=1. Because the two latencies differ, the larger one must set the limit, which gives MAX_OUT=5 and buffers five deep. With these values a stall of a few cycles on R fills the bridge to its limit and shows ready dropping. The 32-bit data width gives four strobe bits, so mixed byte patterns show in the expanded mask.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   function automatic int unsigned lat_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/axil_bridge_fifo.sv
module axil_bridge_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 1) begin : g_bad_depth
      $error("axil_bridge_fifo: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("axil_bridge_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] fill;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         store[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) begin
            wr_ptr <= wr_nxt;
         end
         if (do_pop) begin
            rd_ptr <= rd_nxt;
         end
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   assign dout  = store[rd_ptr];
   assign empty = (fill == '0);
   assign full  = (fill == CNT_W'(DEPTH));

endmodule

// File: rtl/axil_bridge_credit.sv
module axil_bridge_credit #(
   parameter int MAX_OUT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic open_one,
   input  logic close_b,
   input  logic close_r,
   output logic room
);
   localparam int CW = $clog2(MAX_OUT + 1);

   if (MAX_OUT < 1) begin : g_bad_max
      $error("axil_bridge_credit: MAX_OUT must be at least 1");
   end

   logic [CW-1:0] open_q;
   logic [CW-1:0] open_d;

   always_comb begin
      open_d = open_q;
      if (open_one) open_d = open_d + 1'b1;
      if (close_b)  open_d = open_d - 1'b1;
      if (close_r)  open_d = open_d - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= '0;
      end else begin
         open_q <= open_d;
      end
   end

   assign room = (open_q < CW'(MAX_OUT));

endmodule

// File: rtl/axil_bridge_wjoin.sv
module axil_bridge_wjoin #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                allow,
   input  logic                take,
   input  logic                aw_valid,
   output logic                aw_ready,
   input  logic [ADDR_W-1:0]   aw_addr,
   input  logic                w_valid,
   output logic                w_ready,
   input  logic [DATA_W-1:0]   w_data,
   input  logic [DATA_W/8-1:0] w_strb,
   output logic                pair_ok,
   output logic [ADDR_W-1:0]   pair_addr,
   output logic [DATA_W-1:0]   pair_data,
   output logic [DATA_W-1:0]   pair_mask
);
   localparam int NBYTE = DATA_W / 8;

   logic              aw_held, w_held;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [NBYTE-1:0]  strb_q;

   assign aw_ready = allow && !aw_held;
   assign w_ready  = allow && !w_held;

   always_ff @(posedge clk) begin
      if (rst) begin
         aw_held <= 1'b0;
         w_held  <= 1'b0;
      end else begin
         if (aw_valid && aw_ready) begin
            aw_held <= 1'b1;
         end else if (take) begin
            aw_held <= 1'b0;
         end
         if (w_valid && w_ready) begin
            w_held <= 1'b1;
         end else if (take) begin
            w_held <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (aw_valid && aw_ready) begin
         addr_q <= aw_addr;
      end
      if (w_valid && w_ready) begin
         data_q <= w_data;
         strb_q <= w_strb;
      end
   end

   for (genvar gb = 0; gb < NBYTE; gb++) begin : g_mask
      assign pair_mask[gb*8 +: 8] = {8{strb_q[gb]}};
   end

   assign pair_ok   = aw_held && w_held;
   assign pair_addr = addr_q;
   assign pair_data = data_q;

endmodule

// File: rtl/axil_regbus_bridge.sv
module axil_regbus_bridge #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1,
   parameter int WR_LAT = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                aw_valid,
   output logic                aw_ready,
   input  logic [ADDR_W-1:0]   aw_addr,
   input  logic [2:0]          aw_prot,
   input  logic                w_valid,
   output logic                w_ready,
   input  logic [DATA_W-1:0]   w_data,
   input  logic [DATA_W/8-1:0] w_strb,
   output logic                b_valid,
   input  logic                b_ready,
   output logic [1:0]          b_resp,
   input  logic                ar_valid,
   output logic                ar_ready,
   input  logic [ADDR_W-1:0]   ar_addr,
   input  logic [2:0]          ar_prot,
   output logic                r_valid,
   input  logic                r_ready,
   output logic [DATA_W-1:0]   r_data,
   output logic [1:0]          r_resp,
   output logic                rq_valid,
   output logic                rq_write,
   output logic [ADDR_W-1:0]   rq_addr,
   output logic [DATA_W-1:0]   rq_wdata,
   output logic [DATA_W-1:0]   rq_wmask,
   input  logic                rs_valid,
   input  logic [DATA_W-1:0]   rs_rdata,
   input  logic                rs_err
);
   import axil_bridge_pkg::*;

   localparam int BACKEND_LAT = int'(lat_max(RD_LAT, WR_LAT));
   localparam int MAX_OUT     = BACKEND_LAT + 2;
   localparam int RSP_DEPTH   = MAX_OUT;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("axil_regbus_bridge: DATA_W must be a nonzero multiple of 8");
   end
   if (RD_LAT < 1 || WR_LAT < 1) begin : g_bad_lat
      $error("axil_regbus_bridge: latencies must be at least 1");
   end
   if (RSP_DEPTH < MAX_OUT) begin : g_bad_depth
      $error("axil_regbus_bridge: response buffer smaller than outstanding cap");
   end

   logic prot_unused;
   assign prot_unused = ^{aw_prot, ar_prot};

   logic              room;
   logic              rd_issue, wr_issue;
   logic              pair_ok;
   logic [ADDR_W-1:0] pair_addr;
   logic [DATA_W-1:0] pair_data, pair_mask;
   logic              aw_rdy_i, w_rdy_i;

   assign ar_ready = !rst && room;
   assign aw_ready = !rst && aw_rdy_i;
   assign w_ready  = !rst && w_rdy_i;

   assign rd_issue = ar_valid && ar_ready;
   assign wr_issue = pair_ok && room && !rd_issue && !rst;

   axil_bridge_wjoin #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_wjoin (
      .clk       (clk),
      .rst       (rst),
      .allow     (room),
      .take      (wr_issue),
      .aw_valid  (aw_valid && !rst),
      .aw_ready  (aw_rdy_i),
      .aw_addr   (aw_addr),
      .w_valid   (w_valid && !rst),
      .w_ready   (w_rdy_i),
      .w_data    (w_data),
      .w_strb    (w_strb),
      .pair_ok   (pair_ok),
      .pair_addr (pair_addr),
      .pair_data (pair_data),
      .pair_mask (pair_mask)
   );

   assign rq_valid = rd_issue || wr_issue;
   assign rq_write = wr_issue;
   assign rq_addr  = wr_issue ? pair_addr : ar_addr;
   assign rq_wdata = wr_issue ? pair_data : '0;
   assign rq_wmask = wr_issue ? pair_mask : '0;

   logic b_hs, r_hs;
   assign b_hs = b_valid && b_ready;
   assign r_hs = r_valid && r_ready;

   axil_bridge_credit #(
      .MAX_OUT (MAX_OUT)
   ) u_credit (
      .clk      (clk),
      .rst      (rst),
      .open_one (rq_valid),
      .close_b  (b_hs),
      .close_r  (r_hs),
      .room     (room)
   );

   // order of issued request kinds, popped as the backend answers
   logic       kind_head, kind_empty, kind_full_unused;
   axil_bridge_fifo #(
      .WIDTH (1),
      .DEPTH (MAX_OUT)
   ) u_kind (
      .clk   (clk),
      .rst   (rst),
      .push  (rq_valid),
      .din   (rq_write),
      .pop   (rs_valid),
      .dout  (kind_head),
      .empty (kind_empty),
      .full  (kind_full_unused)
   );

   logic [1:0] rs_code;
   logic       to_b, to_r;
   assign rs_code = rs_err ? RESP_SLVERR : RESP_OKAY;
   assign to_b    = rs_valid && !kind_empty && kind_head;
   assign to_r    = rs_valid && !kind_empty && !kind_head;

   logic b_empty, b_full_unused;
   axil_bridge_fifo #(
      .WIDTH (2),
      .DEPTH (RSP_DEPTH)
   ) u_bbuf (
      .clk   (clk),
      .rst   (rst),
      .push  (to_b),
      .din   (rs_code),
      .pop   (b_hs),
      .dout  (b_resp),
      .empty (b_empty),
      .full  (b_full_unused)
   );
   assign b_valid = !b_empty;

   logic                r_empty, r_full_unused;
   logic [DATA_W+1:0]   r_head;
   axil_bridge_fifo #(
      .WIDTH (DATA_W + 2),
      .DEPTH (RSP_DEPTH)
   ) u_rbuf (
      .clk   (clk),
      .rst   (rst),
      .push  (to_r),
      .din   ({rs_code, rs_rdata}),
      .pop   (r_hs),
      .dout  (r_head),
      .empty (r_empty),
      .full  (r_full_unused)
   );
   assign r_valid = !r_empty;
   assign r_resp  = r_head[DATA_W +: 2];
   assign r_data  = r_head[DATA_W-1:0];

endmodule

// File: rtl/axil_regbus_bridge_chk.sv
module axil_regbus_bridge_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1,
   parameter int WR_LAT = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              aw_ready,
   input logic              w_ready,
   input logic              ar_valid,
   input logic              ar_ready,
   input logic              b_valid,
   input logic              b_ready,
   input logic [1:0]        b_resp,
   input logic              r_valid,
   input logic              r_ready,
   input logic [DATA_W-1:0] r_data,
   input logic [1:0]        r_resp,
   input logic              rq_valid,
   input logic              rq_write
);
   localparam int LIMIT = ((RD_LAT > WR_LAT) ? RD_LAT : WR_LAT) + 2;

   int open_cnt;
   always_ff @(posedge clk) begin
      if (rst) begin
         open_cnt <= 0;
      end else begin
         open_cnt <= open_cnt + (rq_valid ? 1 : 0)
                     - ((b_valid && b_ready) ? 1 : 0)
                     - ((r_valid && r_ready) ? 1 : 0);
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!b_valid && !r_valid && !rq_valid));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      open_cnt <= LIMIT);

   p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
      (open_cnt == LIMIT) |-> (!aw_ready && !w_ready && !ar_ready));

   p_read_first_r4: assert property (@(posedge clk) disable iff (rst)
      (ar_valid && ar_ready) |-> (rq_valid && !rq_write));

   p_codes_r7: assert property (@(posedge clk) disable iff (rst)
      (b_valid |-> (b_resp == 2'b00 || b_resp == 2'b10)) and
      (r_valid |-> (r_resp == 2'b00 || r_resp == 2'b10)));

   p_b_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

   p_r_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)));

endmodule

bind axil_regbus_bridge axil_regbus_bridge_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .RD_LAT (RD_LAT),
   .WR_LAT (WR_LAT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .aw_ready (aw_ready),
   .w_ready  (w_ready),
   .ar_valid (ar_valid),
   .ar_ready (ar_ready),
   .b_valid  (b_valid),
   .b_ready  (b_ready),
   .b_resp   (b_resp),
   .r_valid  (r_valid),
   .r_ready  (r_ready),
   .r_data   (r_data),
   .r_resp   (r_resp),
   .rq_valid (rq_valid),
   .rq_write (rq_write)
);

// File: tb/axil_regbus_bridge_test.sv
module axil_regbus_bridge_test;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int RD_LAT = 3;
   localparam int WR_LAT = 1;
   localparam int LAT    = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
   localparam int CAP    = LAT + 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic              aw_valid = 0, aw_ready;
   logic [ADDR_W-1:0] aw_addr = '0;
   logic [2:0]        aw_prot = '0;
   logic              w_valid = 0, w_ready;
   logic [DATA_W-1:0] w_data = '0;
   logic [3:0]        w_strb = '0;
   logic              b_valid, b_ready = 0;
   logic [1:0]        b_resp;
   logic              ar_valid = 0, ar_ready;
   logic [ADDR_W-1:0] ar_addr = '0;
   logic [2:0]        ar_prot = '0;
   logic              r_valid, r_ready = 0;
   logic [DATA_W-1:0] r_data;
   logic [1:0]        r_resp;
   logic              rq_valid, rq_write;
   logic [ADDR_W-1:0] rq_addr;
   logic [DATA_W-1:0] rq_wdata, rq_wmask;
   logic              rs_valid, rs_err;
   logic [DATA_W-1:0] rs_rdata;

   axil_regbus_bridge #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RD_LAT (RD_LAT), .WR_LAT (WR_LAT)
   ) uut (
      .clk (clk), .rst (rst),
      .aw_valid (aw_valid), .aw_ready (aw_ready), .aw_addr (aw_addr), .aw_prot (aw_prot),
      .w_valid (w_valid), .w_ready (w_ready), .w_data (w_data), .w_strb (w_strb),
      .b_valid (b_valid), .b_ready (b_ready), .b_resp (b_resp),
      .ar_valid (ar_valid), .ar_ready (ar_ready), .ar_addr (ar_addr), .ar_prot (ar_prot),
      .r_valid (r_valid), .r_ready (r_ready), .r_data (r_data), .r_resp (r_resp),
      .rq_valid (rq_valid), .rq_write (rq_write), .rq_addr (rq_addr),
      .rq_wdata (rq_wdata), .rq_wmask (rq_wmask),
      .rs_valid (rs_valid), .rs_rdata (rs_rdata), .rs_err (rs_err)
   );

   // bench backend: 16 words, error when the top address bit is set, fixed latency LAT
   logic [DATA_W-1:0] mem [16];
   logic              pv [LAT];
   logic [DATA_W-1:0] pd [LAT];
   logic              pe [LAT];
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 16; i++) mem[i] <= 32'hC0DE0000 + i;
         for (int i = 0; i < LAT; i++) begin
            pv[i] <= 1'b0; pd[i] <= '0; pe[i] <= 1'b0;
         end
      end else begin
         pv[0] <= rq_valid;
         pd[0] <= rq_write ? '0 : mem[rq_addr[5:2]];
         pe[0] <= rq_addr[ADDR_W-1];
         for (int i = 1; i < LAT; i++) begin
            pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; pe[i] <= pe[i-1];
         end
         if (rq_valid && rq_write && !rq_addr[ADDR_W-1])
            mem[rq_addr[5:2]] <= (mem[rq_addr[5:2]] & ~rq_wmask) | (rq_wdata & rq_wmask);
      end
   end
   assign rs_valid = pv[LAT-1];
   assign rs_rdata = pd[LAT-1];
   assign rs_err   = pe[LAT-1];

   // request log
   int          cyc = 0;
   int          lg_n = 0;
   logic        lg_wr   [64];
   logic [31:0] lg_mask [64];
   int          lg_cyc  [64];
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst && rq_valid && lg_n < 64) begin
         lg_wr[lg_n]   <= rq_write;
         lg_mask[lg_n] <= rq_wmask;
         lg_cyc[lg_n]  <= cyc;
         lg_n          <= lg_n + 1;
      end
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_aw(input logic [ADDR_W-1:0] a, input logic [2:0] p);
      aw_valid = 1; aw_addr = a; aw_prot = p;
      #1;
      while (!aw_ready) begin @(negedge clk); #1; end
      @(posedge clk); @(negedge clk);
      aw_valid = 0;
   endtask

   task automatic send_w(input logic [31:0] d, input logic [3:0] s);
      w_valid = 1; w_data = d; w_strb = s;
      #1;
      while (!w_ready) begin @(negedge clk); #1; end
      @(posedge clk); @(negedge clk);
      w_valid = 0;
   endtask

   task automatic send_ar(input logic [ADDR_W-1:0] a, input logic [2:0] p);
      ar_valid = 1; ar_addr = a; ar_prot = p;
      #1;
      while (!ar_ready) begin @(negedge clk); #1; end
      @(posedge clk); @(negedge clk);
      ar_valid = 0;
   endtask

   task automatic get_b(output logic [1:0] resp);
      b_ready = 1;
      #1;
      while (!b_valid) begin @(negedge clk); #1; end
      resp = b_resp;
      @(posedge clk); @(negedge clk);
      b_ready = 0;
   endtask

   task automatic get_r(output logic [31:0] d, output logic [1:0] resp);
      r_ready = 1;
      #1;
      while (!r_valid) begin @(negedge clk); #1; end
      d = r_data; resp = r_resp;
      @(posedge clk); @(negedge clk);
      r_ready = 0;
   endtask

   task automatic t_reset;
      #1;
      chk("R1 b_valid low after reset", 32'(b_valid), 0);
      chk("R1 r_valid low after reset", 32'(r_valid), 0);
      chk("R1 rq_valid low after reset", 32'(rq_valid), 0);
      chk("R1 aw_ready high", 32'(aw_ready), 1);
      chk("R1 w_ready high", 32'(w_ready), 1);
      chk("R1 ar_ready high", 32'(ar_ready), 1);
   endtask

   task automatic t_writes;
      logic [1:0] rs; logic [31:0] d; int n0;
      // W first, full strobe
      n0 = lg_n;
      send_w(32'h11223344, 4'hF);
      #1; chk("R2 w_ready low while W held", 32'(w_ready), 0);
      @(negedge clk);
      chk("R2 no request with W alone", 32'(lg_n), 32'(n0));
      send_aw(8'h04, 3'b000);
      get_b(rs);
      chk("R2 write issued after pair", 32'(lg_n), 32'(n0 + 1));
      chk("R7 write OKAY", 32'(rs), 0);
      // AW first, partial strobe
      n0 = lg_n;
      send_aw(8'h04, 3'b000);
      #1; chk("R2 aw_ready low while AW held", 32'(aw_ready), 0);
      @(negedge clk);
      chk("R2 no request with AW alone", 32'(lg_n), 32'(n0));
      send_w(32'hAABBCCDD, 4'b0101);
      get_b(rs);
      chk("R5 mask expansion", lg_mask[n0], 32'h00FF00FF);
      send_ar(8'h04, 3'b000);
      get_r(d, rs);
      chk("R5 masked write data", d, 32'h11BB33DD);
      chk("R7 read OKAY", 32'(rs), 0);
   endtask

   task automatic t_error;
      logic [1:0] rs; logic [31:0] d;
      send_aw(8'h80, 3'b000);
      send_w(32'hFFFFFFFF, 4'hF);
      get_b(rs);
      chk("R7 write SLVERR", 32'(rs), 32'h2);
      send_ar(8'h84, 3'b000);
      get_r(d, rs);
      chk("R7 read SLVERR", 32'(rs), 32'h2);
   endtask

   task automatic t_prot;
      logic [1:0] rs; logic [31:0] d;
      send_ar(8'h04, 3'b111);
      get_r(d, rs);
      chk("R8 data with ar_prot=7", d, 32'h11BB33DD);
      chk("R8 resp with ar_prot=7", 32'(rs), 0);
      send_aw(8'h10, 3'b111);
      send_w(32'h0BADF00D, 4'hF);
      get_b(rs);
      chk("R8 write resp with aw_prot=7", 32'(rs), 0);
      send_ar(8'h10, 3'b000);
      get_r(d, rs);
      chk("R8 write data with aw_prot=7", d, 32'h0BADF00D);
   endtask

   task automatic t_priority;
      logic [1:0] rs; logic [31:0] d; int n0;
      n0 = lg_n;
      aw_valid = 1; aw_addr = 8'h08; w_valid = 1; w_data = 32'h00000055; w_strb = 4'hF;
      ar_valid = 1; ar_addr = 8'h0C;
      #1;
      chk("R4 all readies high", 32'({aw_ready, w_ready, ar_ready}), 32'h7);
      @(posedge clk); @(negedge clk);
      aw_valid = 0; w_valid = 0; ar_valid = 0;
      @(negedge clk);
      chk("R4 two requests", 32'(lg_n), 32'(n0 + 2));
      chk("R4 read issued first", 32'(lg_wr[n0]), 0);
      chk("R4 write issued next", 32'(lg_wr[n0 + 1]), 1);
      chk("R4 write one cycle later", 32'(lg_cyc[n0 + 1] - lg_cyc[n0]), 1);
      get_r(d, rs);
      chk("R4 read data", d, 32'hC0DE0003);
      get_b(rs);
      chk("R4 write resp", 32'(rs), 0);
   endtask

   task automatic t_cap;
      logic [1:0] rs; logic [31:0] d, d0; int acc;
      logic hs;
      acc = 0;
      ar_valid = 1; ar_addr = 8'h20;
      for (int k = 0; k < 14; k++) begin
         #1; hs = ar_ready;
         if (hs) acc++;
         @(posedge clk); @(negedge clk);
         if (hs) ar_addr = ar_addr + 8'h04;
      end
      #1;
      chk("R3 ar_ready low at cap", 32'(ar_ready), 0);
      chk("R3 aw_ready low at cap", 32'(aw_ready), 0);
      chk("R10 accepted exactly cap", 32'(acc), 32'(CAP));
      ar_valid = 0;
      d0 = r_data;
      chk("R9 r_valid held while stalled", 32'(r_valid), 1);
      @(negedge clk); @(negedge clk); #1;
      chk("R9 r_data stable while stalled", r_data, d0);
      for (int k = 0; k < CAP; k++) begin
         get_r(d, rs);
         chk("R6 read order data", d, 32'hC0DE0008 + 32'(k));
      end
      #1;
      chk("R3 ar_ready back after drain", 32'(ar_ready), 1);
   endtask

   task automatic t_border;
      logic [1:0] rs;
      send_aw(8'h90, 3'b000); send_w(32'h1, 4'hF);
      send_aw(8'h14, 3'b000); send_w(32'h2, 4'hF);
      get_b(rs);
      chk("R6 first write resp in order", 32'(rs), 32'h2);
      get_b(rs);
      chk("R6 second write resp in order", 32'(rs), 0);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 0;
      t_reset();
      @(negedge clk);
      t_writes();
      t_error();
      t_prot();
      t_priority();
      t_cap();
      t_border();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule